// File: doc/BRIEF.md
# Block Copy and Byte Search Sequencer

This block walks a byte-wide synchronous memory on behalf of a processor core. It runs two kinds of step. A copy step moves one byte from a source pointer to a destination pointer. A search step compares one byte at the source pointer with an 8-bit key. Each kind can run upward or downward through memory, and can run a single step or repeat on its own until it reaches its stopping condition.

The core loads a source pointer, a destination pointer, a 16-bit count and a key. It then pulses `start_i` with three mode bits. From that point the engine owns the memory port. It raises `busy_o` and issues read and write cycles. It finishes with a one-cycle `done_o` pulse. At that point the final pointer and count values are on `hl_o`, `de_o` and `bc_o`, together with a match flag and a count-not-zero flag.

Top module: `blkxfer_engine`

## Requirements
- R1: A copy step reads the byte at the source pointer and writes it to the address in the destination pointer. It then steps both pointers by one and lowers the count by one.
- R2: With `dir_down_i`=0 the pointers are incremented on every step. With `dir_down_i`=1 they are decremented.
- R3: A search step reads the byte at the source pointer and compares it with `key_i`, without writing memory. Only the source pointer steps, the count drops by one, and the destination pointer is left unchanged.
- R4: A repeating copy (`op_copy_i`=1, `repeat_i`=1) keeps stepping until the count becomes zero.
- R5: A repeating search (`op_copy_i`=0, `repeat_i`=1) stops after the first step in which either the count becomes zero or the byte read equals the key.
- R6: With `repeat_i`=0, exactly one step is performed, whatever the count and the compare result.
- R7: Pointer and count arithmetic wraps modulo 2^16. A step taken with a count of 0 leaves 0xFFFF, and incrementing 0xFFFF gives 0x0000.
- R8: Read data returns one cycle after `mem_rd_o`. Each step therefore takes two cycles, a read cycle followed by a write or compare cycle. `done_o` rises 1+2N cycles after the edge that accepts `start_i`, where N is the number of steps.
- R9: At `done_o`, `match_o` is 1 exactly when the last step was a search whose byte equalled the key, and `cnt_nz_o` is 1 exactly when the final count is not zero.
- R10: `busy_o` is high from the cycle after start is accepted, through the single-cycle `done_o` pulse, and is low the cycle after it. A `start_i` pulse while `busy_o` is high has no effect on the operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, accepted only while idle |
| op_copy_i | input | 1 | 1 = copy, 0 = search |
| dir_down_i | input | 1 | 1 = pointers decrement, 0 = increment |
| repeat_i | input | 1 | 1 = repeat until the stop condition, 0 = single step |
| hl_i | input | 16 | Initial source pointer |
| de_i | input | 16 | Initial destination pointer |
| bc_i | input | 16 | Initial count |
| key_i | input | 8 | Search key |
| mem_addr_o | output | 16 | Memory address |
| mem_rd_o | output | 1 | Read request; data is valid the next cycle |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| hl_o | output | 16 | Current source pointer |
| de_o | output | 16 | Current destination pointer |
| bc_o | output | 16 | Current count |
| match_o | output | 1 | Last search byte equalled the key |
| cnt_nz_o | output | 1 | Count is not zero |

## Verification
Copies run in both directions, both as single steps and as repeats, and include an overlapping downward move. The memory image therefore shows whether the sequence of reads and writes is correct, and not only the final pointer values. Searches are run with the key hit in the middle of the range, with the key hit on the very last byte, and with the key absent. This separates a stop on match from a stop on count, and shows whether the match flag and the count flag are produced independently. Single steps started with a count of zero, or with a pointer at 0xFFFF, expose the wrap. A second start strobe issued partway through an operation shows whether the engine ignores start while busy.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_READ = 2'd1,
      ST_STEP = 2'd2,
      ST_FIN  = 2'd3
   } seq_state_e;

   typedef struct packed {
      logic copy;
      logic down;
      logic rpt;
   } op_mode_t;

endpackage

// File: rtl/blkxfer_ptr.sv
module blkxfer_ptr #(
   parameter int W         = 16,
   parameter bit DOWN_ONLY = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic         step_i,
   input  logic         down_i,
   output logic [W-1:0] val_o
);

   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] val_q;
   logic [W-1:0] nxt;

   generate
      if (W < 1) begin : g_bad_w
         $error("blkxfer_ptr: W must be at least 1");
      end
      if (DOWN_ONLY) begin : g_down_only
         assign nxt = val_q - ONE;
      end else begin : g_updown
         assign nxt = down_i ? (val_q - ONE) : (val_q + ONE);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)      val_q <= '0;
      else if (load_i) val_q <= load_val_i;
      else if (step_i) val_q <= nxt;
   end

   assign val_o = val_q;

endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
   import blkxfer_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  op_mode_t          mode_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic [DATA_W-1:0] rdata_i,
   input  logic [DATA_W-1:0] key_i,
   output logic              load_o,
   output logic              step_src_o,
   output logic              step_dst_o,
   output logic              step_cnt_o,
   output logic              rd_o,
   output logic              wr_o,
   output logic              sel_dst_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              match_o,
   output op_mode_t          mode_o
);

   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   seq_state_e state_q, state_d;
   op_mode_t   mode_q;
   logic       match_q;
   logic       hit;
   logic       last_cnt;
   logic       stop;

   generate
      if (CNT_W < 1 || DATA_W < 1) begin : g_bad_par
         $error("blkxfer_seq: widths must be positive");
      end
   endgenerate

   assign hit      = (rdata_i == key_i);
   assign last_cnt = (cnt_i == CNT_ONE);
   assign stop     = !mode_q.rpt || last_cnt || (!mode_q.copy && hit);

   always_comb begin
      state_d    = state_q;
      load_o     = 1'b0;
      step_src_o = 1'b0;
      step_dst_o = 1'b0;
      step_cnt_o = 1'b0;
      rd_o       = 1'b0;
      wr_o       = 1'b0;
      sel_dst_o  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               load_o  = 1'b1;
               state_d = ST_READ;
            end
         end
         ST_READ: begin
            rd_o    = 1'b1;
            state_d = ST_STEP;
         end
         ST_STEP: begin
            step_src_o = 1'b1;
            step_cnt_o = 1'b1;
            step_dst_o = mode_q.copy;
            wr_o       = mode_q.copy;
            sel_dst_o  = mode_q.copy;
            state_d    = stop ? ST_FIN : ST_READ;
         end
         ST_FIN: begin
            state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         mode_q  <= '0;
         match_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (load_o) begin
            mode_q  <= mode_i;
            match_q <= 1'b0;
         end else if (state_q == ST_STEP) begin
            match_q <= !mode_q.copy && hit;
         end
      end
   end

   assign busy_o  = (state_q != ST_IDLE);
   assign done_o  = (state_q == ST_FIN);
   assign match_o = match_q;
   assign mode_o  = mode_q;

   // R8: a write always follows the read of the same step
   assert_wr_after_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_o |-> $past(rd_o));
   // R8: read and write never share a cycle
   assert_no_dual_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_o && wr_o));
   // R10: the done pulse lasts a single cycle
   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R10: busy cannot drop before done
   assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o) |=> busy_o);

endmodule

// File: rtl/blkxfer_engine.sv
module blkxfer_engine
   import blkxfer_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              op_copy_i,
   input  logic              dir_down_i,
   input  logic              repeat_i,
   input  logic [ADDR_W-1:0] hl_i,
   input  logic [ADDR_W-1:0] de_i,
   input  logic [CNT_W-1:0]  bc_i,
   input  logic [DATA_W-1:0] key_i,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic              mem_rd_o,
   output logic              mem_wr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [ADDR_W-1:0] hl_o,
   output logic [ADDR_W-1:0] de_o,
   output logic [CNT_W-1:0]  bc_o,
   output logic              match_o,
   output logic              cnt_nz_o
);

   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   generate
      if (ADDR_W < 2 || CNT_W < 2 || DATA_W < 1) begin : g_bad_par
         $error("blkxfer_engine: parameter out of range");
      end
   endgenerate

   op_mode_t    mode_in, mode_cur;
   logic        load, step_src, step_dst, step_cnt, sel_dst;
   logic [ADDR_W-1:0] hl_q, de_q;
   logic [CNT_W-1:0]  bc_q;

   assign mode_in.copy = op_copy_i;
   assign mode_in.down = dir_down_i;
   assign mode_in.rpt  = repeat_i;

   blkxfer_seq #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .mode_i     (mode_in),
      .cnt_i      (bc_q),
      .rdata_i    (mem_rdata_i),
      .key_i      (key_i),
      .load_o     (load),
      .step_src_o (step_src),
      .step_dst_o (step_dst),
      .step_cnt_o (step_cnt),
      .rd_o       (mem_rd_o),
      .wr_o       (mem_wr_o),
      .sel_dst_o  (sel_dst),
      .busy_o     (busy_o),
      .done_o     (done_o),
      .match_o    (match_o),
      .mode_o     (mode_cur)
   );

   blkxfer_ptr #(.W(ADDR_W), .DOWN_ONLY(1'b0)) u_src (
      .clk (clk), .rst_n (rst_n), .load_i (load), .load_val_i (hl_i),
      .step_i (step_src), .down_i (mode_cur.down), .val_o (hl_q)
   );

   blkxfer_ptr #(.W(ADDR_W), .DOWN_ONLY(1'b0)) u_dst (
      .clk (clk), .rst_n (rst_n), .load_i (load), .load_val_i (de_i),
      .step_i (step_dst), .down_i (mode_cur.down), .val_o (de_q)
   );

   blkxfer_ptr #(.W(CNT_W), .DOWN_ONLY(1'b1)) u_cnt (
      .clk (clk), .rst_n (rst_n), .load_i (load), .load_val_i (bc_i),
      .step_i (step_cnt), .down_i (1'b1), .val_o (bc_q)
   );

   assign mem_addr_o  = sel_dst ? de_q : hl_q;
   assign mem_wdata_o = mem_rdata_i;
   assign hl_o        = hl_q;
   assign de_o        = de_q;
   assign bc_o        = bc_q;
   assign cnt_nz_o    = (bc_q != '0);

   // R1: every step lowers the count by one, modulo 2^16
   assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (step_cnt && !load) |=> (bc_q == $past(bc_q) - CNT_ONE));
   // R3: a search step leaves the destination pointer alone
   assert_dst_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (step_src && !mode_cur.copy) |=> $stable(de_q));
   // R4: a repeating copy only finishes with the count at zero
   assert_copy_rep_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && mode_cur.rpt && mode_cur.copy) |-> (bc_q == '0));
   // R5: a repeating search finishes on a hit or an exhausted count
   assert_search_rep_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && mode_cur.rpt && !mode_cur.copy) |-> (match_o || bc_q == '0));
   // R3: a search never writes memory
   assert_search_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !mode_cur.copy) |-> !mem_wr_o);

endmodule

// File: tb/blkxfer_engine_tb_top.sv
module blkxfer_engine_tb_top;

   localparam int CLK_PERIOD = 10;

   typedef struct {
      logic [15:0] hl;
      logic [15:0] de;
      logic [15:0] bc;
      logic        match;
      logic        nz;
      int          done_cyc;
      string       tag;
   } exp_item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        op_copy = 1'b0, dir_down = 1'b0, rpt = 1'b0;
   logic [15:0] hl_in = '0, de_in = '0, bc_in = '0;
   logic [7:0]  key = '0;
   logic [15:0] mem_addr;
   logic        mem_rd, mem_wr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = '0;
   logic        busy, done;
   logic [15:0] hl_out, de_out, bc_out;
   logic        match, cnt_nz;

   logic [7:0]  mem    [256];
   logic [7:0]  shadow [256];
   exp_item_t   sb_q [$];
   int          cyc = 0;
   int          checks = 0;
   int          errors = 0;
   logic        prev_done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   blkxfer_engine dut_i (
      .clk (clk), .rst_n (rst_n), .start_i (start),
      .op_copy_i (op_copy), .dir_down_i (dir_down), .repeat_i (rpt),
      .hl_i (hl_in), .de_i (de_in), .bc_i (bc_in), .key_i (key),
      .mem_addr_o (mem_addr), .mem_rd_o (mem_rd), .mem_wr_o (mem_wr),
      .mem_wdata_o (mem_wdata), .mem_rdata_i (mem_rdata),
      .busy_o (busy), .done_o (done), .hl_o (hl_out), .de_o (de_out),
      .bc_o (bc_out), .match_o (match), .cnt_nz_o (cnt_nz)
   );

   // synchronous memory, one-cycle read latency (R8)
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
      if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // monitor: pop expected results as done pulses appear
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_done) check(!busy, "R10", "busy after done", busy, 0);
         if (done) begin
            if (sb_q.size() == 0) begin
               check(1'b0, "R10", "done with nothing pending", 1, 0);
            end else begin
               exp_item_t e;
               e = sb_q.pop_front();
               check(busy, "R10", {e.tag, " busy at done"}, busy, 1);
               check(hl_out == e.hl, "R1", {e.tag, " source ptr"}, hl_out, e.hl);
               check(de_out == e.de, "R2", {e.tag, " dest ptr"}, de_out, e.de);
               check(bc_out == e.bc, "R7", {e.tag, " count"}, bc_out, e.bc);
               check(match == e.match, "R9", {e.tag, " match"}, match, e.match);
               check(cnt_nz == e.nz, "R9", {e.tag, " cnt_nz"}, cnt_nz, e.nz);
               check(cyc == e.done_cyc, "R8", {e.tag, " done cycle"}, cyc, e.done_cyc);
            end
         end
         prev_done <= done;
      end
   end

   // driver: model the operation, push the expectation, run it
   task automatic run_op(input logic c, input logic d, input logic r,
                         input logic [15:0] h, input logic [15:0] de,
                         input logic [15:0] b, input logic [7:0] k,
                         input bit poke, input string tag);
      exp_item_t e;
      logic [15:0] mh = h, md = de, mb = b;
      logic hit = 1'b0;
      int n = 0;
      bit fin = 1'b0;
      while (!fin) begin
         if (c) shadow[md[7:0]] = shadow[mh[7:0]];
         else   hit = (shadow[mh[7:0]] == k);
         mh = d ? mh - 16'd1 : mh + 16'd1;
         if (c) md = d ? md - 16'd1 : md + 16'd1;
         mb = mb - 16'd1;
         n++;
         fin = !r || (mb == 16'd0) || (!c && hit);
      end
      @(negedge clk);
      e.hl = mh; e.de = md; e.bc = mb;
      e.match = !c && hit; e.nz = (mb != 16'd0);
      e.done_cyc = cyc + 1 + 2*n;
      e.tag = tag;
      sb_q.push_back(e);
      op_copy = c; dir_down = d; rpt = r;
      hl_in = h; de_in = de; bc_in = b; key = k;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         // R10: a second start while busy must not disturb the run
         @(negedge clk);
         op_copy = ~c; dir_down = ~d; rpt = 1'b0;
         hl_in = 16'h00A0; de_in = 16'h00B0; bc_in = 16'd1; key = ~k;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (busy) @(negedge clk);
      @(negedge clk);
      begin
         int bad = -1;
         for (int i = 0; i < 256; i++)
            if (bad < 0 && mem[i] !== shadow[i]) bad = i;
         check(bad < 0, c ? "R1" : "R3", {tag, " memory image"},
               bad < 0 ? 0 : int'(mem[bad]), bad < 0 ? 0 : int'(shadow[bad]));
      end
   endtask

   initial begin
      for (int i = 0; i < 256; i++) begin
         mem[i]    = 8'(i * 7 + 3);
         shadow[i] = 8'(i * 7 + 3);
      end
      repeat (3) @(negedge clk);
      check(!busy && !done, "R10", "reset busy/done", {busy, done}, 0);
      check(!mem_rd && !mem_wr, "R8", "reset memory strobes", {mem_rd, mem_wr}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 R2 R6: single upward copy
      run_op(1, 0, 0, 16'h0010, 16'h0080, 16'd5, 8'h00, 0, "R6 single copy up");
      // R2: single downward copy
      run_op(1, 1, 0, 16'h0020, 16'h0090, 16'd3, 8'h00, 0, "R2 single copy down");
      // R4: repeated upward copy
      run_op(1, 0, 1, 16'h0030, 16'h00C0, 16'd5, 8'h00, 0, "R4 repeat copy up");
      // R4 R2: repeated downward copy with overlap
      run_op(1, 1, 1, 16'h0063, 16'h0065, 16'd4, 8'h00, 0, "R4 repeat copy down overlap");
      // R3 R6: single search with no hit
      run_op(0, 0, 0, 16'h0010, 16'h1234, 16'd6, 8'hEE, 0, "R3 single search");
      // R5: repeated search, hit in the middle
      run_op(0, 0, 1, 16'h0040, 16'h1234, 16'd8, shadow[8'h42], 0, "R5 search hit middle");
      // R5: repeated downward search, no hit, ends on count
      run_op(0, 1, 1, 16'h0048, 16'h4321, 16'd4, 8'hEE, 0, "R5 search miss down");
      // R9: hit on the last byte, count reaches zero together
      run_op(0, 0, 1, 16'h0050, 16'h0000, 16'd3, shadow[8'h52], 0, "R9 hit on last");
      // R6: single search with hit, only one step
      run_op(0, 0, 0, 16'h0058, 16'h0000, 16'd9, shadow[8'h58], 0, "R6 single search hit");
      // R7: single step with zero count and pointer wrap
      run_op(1, 0, 0, 16'hFFFF, 16'hFFFF, 16'd0, 8'h00, 0, "R7 wrap up zero count");
      run_op(0, 1, 0, 16'h0000, 16'h0007, 16'd0, 8'h00, 0, "R7 wrap down");
      // R10: start ignored while busy
      run_op(1, 0, 1, 16'h0070, 16'h00E0, 16'd6, 8'h00, 1, "R10 start while busy");
      repeat (3) @(negedge clk);
      check(sb_q.size() == 0, "R10", "pending results", sb_q.size(), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      errors++;
      checks++;
      $display("FAIL R10 watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule